// File: doc/BRIEF.md
# Scanline Window Wait Unit

This block holds a display command executor while the raster position sits on the wrong side of a scanline window. The executor hands it one 64-bit wait instruction and a one-cycle start strobe. The instruction carries an opcode, a lower scanline bound and an upper scanline bound. The unit then compares a registered copy of the live scanline count from the timing generator against the inclusive window `[lower, upper]`. It raises `done_o` for one cycle once the wait may end.

Two opcodes share the same window and have opposite meanings. The enter-wait opcode holds the executor until the scanline falls inside the window. The leave-wait opcode holds it while the scanline is inside the window, and releases once the scanline is outside. The window never wraps: software always issues `upper >= lower` and folds any frame wrap into the choice of opcode. A leave-wait on the window `[0, 0]` therefore holds only while the counter reads zero. This case covers a counter that reports zero while the display sits in a low-power state.

Top module: `scanline_window_wait`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are both low.
- R2: The opcode is instruction bits [63:56]. The lower bound is bits [LINE_W-1:0] and the upper bound is bits [20+LINE_W-1:20]. No other instruction bit affects behaviour.
- R3: Opcode 0x05 (enter-wait) holds `busy_o` high while the sampled scanline is below the lower bound or above the upper bound. It releases once the scanline is inside the window.
- R4: Opcode 0x06 (leave-wait) holds `busy_o` high while the sampled scanline is inside the window. It releases once the scanline is outside the window.
- R5: Both bounds are inclusive. A scanline equal to either bound counts as inside, up to the largest value LINE_W bits can hold.
- R6: A start accepted at clock edge k raises `busy_o` after edge k. If the scanline already meets the release condition, `done_o` is high after edge k+1.
- R7: The scanline is sampled into a register every clock. If a releasing value is present before edge j, `done_o` rises after edge j+1 and not earlier.
- R8: `done_o` is high for exactly one cycle. `busy_o` falls on the same edge at which `done_o` rises, and the two are never high together.
- R9: A start while `busy_o` is high is ignored. The pending wait keeps its own opcode and window.
- R10: A start whose opcode is neither 0x05 nor 0x06 is ignored. `busy_o` stays low and no `done_o` pulse follows.
- R11: A leave-wait with both bounds 0 holds only while the scanline is exactly 0. It releases at once for any nonzero scanline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a wait |
| instr_i | input | 64 | Wait instruction: opcode, upper and lower bounds |
| line_i | input | LINE_W | Current scanline from the timing generator |
| busy_o | output | 1 | A wait is pending |
| done_o | output | 1 | One-cycle pulse: the wait has ended |

## Verification
A wrong stored bound or a wrong mode bit shows at the ports as a release on the wrong scanline. The bench finds it two edges after it moves the scanline to a value just outside, or exactly on, a bound. A stall value that should have held the wait instead produces a `done_o` pulse within the first two cycles after the start. A stale sampled scanline shows as `done_o` arriving one cycle early or one cycle late against the fixed two-edge release latency. The bench checks that latency on every wait. A wait that was lost or overwritten by an ignored start shows as `busy_o` falling while the scanline still meets the stall condition.

// File: rtl/sline_wait_pkg.sv
package sline_wait_pkg;

    // Bit position of the fields inside the 64-bit wait instruction
    localparam int unsigned OPC_LSB   = 56;
    localparam int unsigned OPC_W     = 8;
    localparam int unsigned UPPER_LSB = 20;
    localparam int unsigned LOWER_LSB = 0;

    // Opcodes the unit accepts
    localparam logic [OPC_W-1:0] OPC_WAIT_ENTER = 8'h05;
    localparam logic [OPC_W-1:0] OPC_WAIT_LEAVE = 8'h06;

    // Which side of the window releases the wait
    typedef enum logic {
        MODE_ENTER = 1'b0,   // release once inside
        MODE_LEAVE = 1'b1    // release once outside
    } wait_mode_e;

endpackage

// File: rtl/sline_sampler.sv
module sline_sampler #(
    parameter int unsigned LINE_W = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] line_o
);

    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        line_d = line_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/sline_decode.sv
module sline_decode
    import sline_wait_pkg::*;
#(
    parameter int unsigned LINE_W = 13
) (
    input  logic [63:0]       instr_i,
    output logic              valid_o,
    output wait_mode_e        mode_o,
    output logic [LINE_W-1:0] lower_o,
    output logic [LINE_W-1:0] upper_o
);

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc     = instr_i[OPC_LSB +: OPC_W];
        lower_o = instr_i[LOWER_LSB +: LINE_W];
        upper_o = instr_i[UPPER_LSB +: LINE_W];
        valid_o = (opc == OPC_WAIT_ENTER) || (opc == OPC_WAIT_LEAVE);
        mode_o  = (opc == OPC_WAIT_LEAVE) ? MODE_LEAVE : MODE_ENTER;
    end

endmodule

// File: rtl/sline_window_cmp.sv
module sline_window_cmp
    import sline_wait_pkg::*;
#(
    parameter int unsigned LINE_W = 13
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] lower_i,
    input  logic [LINE_W-1:0] upper_i,
    input  wait_mode_e        mode_i,
    output logic              inside_o,
    output logic              release_o
);

    logic ge_lower, le_upper;

    always_comb begin
        ge_lower  = (line_i >= lower_i);
        le_upper  = (line_i <= upper_i);
        inside_o  = ge_lower && le_upper;
        release_o = (mode_i == MODE_LEAVE) ? !inside_o : inside_o;
    end

endmodule

// File: rtl/scanline_window_wait.sv
module scanline_window_wait
    import sline_wait_pkg::*;
#(
    parameter int unsigned LINE_W = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [63:0]       instr_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [63:0] LOWER_MASK = ((64'd1 << LINE_W) - 64'd1) << LOWER_LSB;
    localparam logic [63:0] UPPER_MASK = ((64'd1 << LINE_W) - 64'd1) << UPPER_LSB;
    localparam logic [63:0] OPC_MASK   = ((64'd1 << OPC_W) - 64'd1) << OPC_LSB;
    localparam logic [63:0] USED_MASK  = LOWER_MASK | UPPER_MASK | OPC_MASK;

    typedef struct packed {
        logic              busy;
        logic              done;
        wait_mode_e        mode;
        logic [LINE_W-1:0] lower;
        logic [LINE_W-1:0] upper;
    } wait_state_t;

    wait_state_t st_d, st_q;

    logic              dec_valid;
    wait_mode_e        dec_mode;
    logic [LINE_W-1:0] dec_lower, dec_upper;
    logic [LINE_W-1:0] line_q;
    logic              win_inside, win_release;
    logic              unused_instr;

    // Bits outside the three fields carry no meaning for this unit
    assign unused_instr = ^(instr_i & ~USED_MASK);

    sline_sampler #(.LINE_W(LINE_W)) u_sampler (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .line_o (line_q)
    );

    sline_decode #(.LINE_W(LINE_W)) u_decode (
        .instr_i (instr_i),
        .valid_o (dec_valid),
        .mode_o  (dec_mode),
        .lower_o (dec_lower),
        .upper_o (dec_upper)
    );

    sline_window_cmp #(.LINE_W(LINE_W)) u_cmp (
        .line_i    (line_q),
        .lower_i   (st_q.lower),
        .upper_i   (st_q.upper),
        .mode_i    (st_q.mode),
        .inside_o  (win_inside),
        .release_o (win_release)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            // Pending wait: only the sampled line can end it
            if (win_release) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i && dec_valid) begin
            st_d.busy  = 1'b1;
            st_d.mode  = dec_mode;
            st_d.lower = dec_lower;
            st_d.upper = dec_upper;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, done: 1'b0, mode: MODE_ENTER,
                      lower: '0, upper: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

    // R8: single-cycle done
    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: busy and done never together
    a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    // R8: done only ends a pending wait
    a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_o));

    // R3/R4: a pending wait without release stays pending
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !win_release) |=> (busy_o && !done_o));

    // R9: window and mode stay fixed while pending
    a_r9_stable_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(st_q.lower) && $stable(st_q.upper)
                                       && $stable(st_q.mode)));

    // R10: unknown opcode leaves the unit idle
    a_r10_bad_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && !dec_valid) |=> !busy_o);

    // R6: a valid start from idle makes the unit busy
    a_r6_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && dec_valid) |=> busy_o);

endmodule

// File: tb/test_scanline_window_wait.sv
`timescale 1ns/1ps
module test_scanline_window_wait;

    localparam int unsigned LW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   instr = '0;
    logic [LW-1:0] line = '0;
    logic          busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scanline_window_wait #(.LINE_W(LW)) i_scanline_window_wait (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .instr_i (instr),
        .line_i  (line),
        .busy_o  (busy),
        .done_o  (done)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [63:0] mk(input logic [7:0] opc, input int lo, input int up,
                                      input logic [63:0] junk);
        return (64'(opc) << 56) | (64'(up) << 20) | 64'(lo) | junk;
    endfunction

    // Wait that first stalls for some cycles, then releases
    task automatic wait_stall(input logic [7:0] opc, input int lo, input int up,
                              input logic [63:0] junk, input int stall_ln,
                              input int rel_ln, input string tag);
        line  = LW'(stall_ln);
        instr = mk(opc, lo, up, junk);
        start = 1'b1;
        step();
        start = 1'b0;
        check({31'b0, busy}, 1, {tag, " R6 busy after start"});
        for (int i = 0; i < 3; i++) begin
            step();
            check({30'b0, busy, done}, 2, {tag, " stall held"});
        end
        line = LW'(rel_ln);
        step();
        check({30'b0, busy, done}, 2, {tag, " R7 no early release"});
        step();
        check({30'b0, busy, done}, 1, {tag, " R7 release after two edges"});
        step();
        check({30'b0, busy, done}, 0, {tag, " R8 done one cycle"});
    endtask

    // Wait whose condition is already met
    task automatic wait_now(input logic [7:0] opc, input int lo, input int up,
                            input int ln, input string tag);
        line  = LW'(ln);
        instr = mk(opc, lo, up, 64'h0);
        start = 1'b1;
        step();
        start = 1'b0;
        check({30'b0, busy, done}, 2, {tag, " R6 busy first cycle"});
        step();
        check({30'b0, busy, done}, 1, {tag, " R6 done next cycle"});
        step();
        check({30'b0, busy, done}, 0, {tag, " R8 idle after done"});
    endtask

    task automatic t_reset();
        check({30'b0, busy, done}, 0, "R1 during reset");
        rst_n = 1'b1;
        step();
        check({30'b0, busy, done}, 0, "R1 after reset");
    endtask

    task automatic t_enter();
        wait_stall(8'h05, 100, 200, 64'h0, 50, 100, "R3 R5 enter at lower");
        wait_stall(8'h05, 100, 200, 64'h0, 201, 200, "R3 R5 enter at upper");
        wait_now(8'h05, 100, 200, 150, "R3 inside now");
    endtask

    task automatic t_leave();
        wait_stall(8'h06, 100, 200, 64'h0, 150, 201, "R4 leave above");
        wait_stall(8'h06, 100, 200, 64'h0, 100, 99, "R4 R5 leave below");
        wait_now(8'h06, 100, 200, 300, "R4 outside now");
    endtask

    task automatic t_zero();
        wait_stall(8'h06, 0, 0, 64'h0, 0, 1, "R11 zero window");
        wait_now(8'h06, 0, 0, 5, "R11 nonzero releases");
    endtask

    task automatic t_fields();
        // junk in bits between the fields and below the opcode
        wait_stall(8'h05, 300, 400, 64'h00FF_FFFE_000F_E000, 299, 400, "R2 field positions");
        wait_now(8'h05, 8190, 8191, 8191, "R5 top bound");
    endtask

    task automatic t_busy_ignore();
        line  = LW'(10);
        instr = mk(8'h05, 100, 200, 64'h0);
        start = 1'b1;
        step();
        instr = mk(8'h05, 0, 50, 64'h0);   // would release at line 10
        step();
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check({30'b0, busy, done}, 2, "R9 second start ignored");
        end
        line = LW'(150);
        step();
        step();
        check({30'b0, busy, done}, 1, "R9 original window releases");
        step();
    endtask

    task automatic t_bad_opc();
        line  = LW'(10);
        instr = mk(8'h01, 0, 8000, 64'h0);
        start = 1'b1;
        step();
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check({30'b0, busy, done}, 0, "R10 unknown opcode idle");
            step();
        end
    endtask

    initial begin
        step();
        step();
        t_reset();
        t_enter();
        t_leave();
        t_zero();
        t_fields();
        t_busy_ignore();
        t_bad_opc();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule